// File: doc/BRIEF.md
# Packed-RGB Bilinear Blend Pipeline

This block blends four neighbouring colour pixels into one output pixel by bilinear weighting. Each pixel is a packed 24-bit word holding three 8-bit channels. A pair of unsigned fractional offsets, `frac_x` and `frac_y`, places the sample point inside the square the four neighbours span. Both offsets carry `FRAC_W` fraction bits. The block computes the product of the two offsets once, derives all four weights from it, and then blends the three channels side by side with separate multiply-add trees.

The pipeline takes a new sample on every clock and has a fixed depth of four stages. A valid bit travels with the data. A per-sample in-range flag lets the coordinate generator upstream mark samples that fall outside the source image; the block then outputs black for those samples. The block does not fetch pixels and does not generate coordinates.

Top module: `rgb_bilerp`

## Requirements
- R1: Channel c (c = 0, 1, 2) of every pixel word occupies bits 8c+7 down to 8c. Each channel is blended using only the same channel of the four inputs.
- R2: Let dx = frac_x and dy = frac_y, let ONE = 2^FRAC_W, and let P = floor(dx*dy / 2^FRAC_W). The weights are: w00 = ONE + P - dx - dy, w10 = dx - P, w01 = dy - P, w11 = P. The four weights always add up to ONE.
- R3: w00 scales `pix00`, w10 scales `pix10`, w01 scales `pix01` and w11 scales `pix11`. When both offsets are zero, the output equals `pix00` exactly.
- R4: Each output channel equals floor((sum of weight times channel) / 2^FRAC_W). This value is clamped to the range 0 to 255 before packing.
- R5: A valid sample whose `in_range` is low produces `out_pix` = 0.
- R6: `out_valid` equals `in_valid` from four clocks earlier. The blended pixel for a sample appears on `out_pix` in that same cycle.
- R7: A new sample is accepted on every clock, with no gaps required between valid samples.
- R8: While `out_valid` is low, `out_pix` is 0.
- R9: A synchronous reset clears `out_valid` and `out_pix`. After reset no sample that was in flight before it reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is present |
| in_range | input | 1 | Sample maps inside the source image |
| pix00 | input | 24 | Neighbour at (x0, y0) |
| pix10 | input | 24 | Neighbour at (x1, y0) |
| pix01 | input | 24 | Neighbour at (x0, y1) |
| pix11 | input | 24 | Neighbour at (x1, y1) |
| frac_x | input | FRAC_W | Fractional x offset |
| frac_y | input | FRAC_W | Fractional y offset |
| out_valid | output | 1 | Output pixel is present |
| out_pix | output | 24 | Blended packed pixel |

## Verification
The blend is driven with several offset patterns, and each pattern isolates a different part of the block:
- Zero offsets show that `pix00` passes through unchanged.
- Offsets of exactly one half give equal weights, which exposes the truncation.
- Offsets that differ per axis tell a swap of `pix10` and `pix01` apart from a correct mapping.
- Offsets at the largest fractional value stress the floor of the shared product and the w00 term.

The neighbour words carry distinct values in each channel, so a channel swap or a mis-sliced byte shows up at once. Streams arrive back to back and with gaps, and some samples have `in_range` low, to confirm the four-cycle alignment and the zeroing. A reset in the middle of a stream confirms that in-flight samples are dropped.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;
    localparam int CH_W      = 8;
    localparam int NCH       = 3;
    localparam int PIX_W     = CH_W * NCH;
    localparam int FRAC_DEF  = 12;
    localparam int LATENCY   = 4;

    typedef logic [NCH-1:0][CH_W-1:0] rgb_t;

    typedef struct packed {
        logic vld;
        logic rng;
    } ctl_t;

    typedef struct packed {
        rgb_t p00;
        rgb_t p10;
        rgb_t p01;
        rgb_t p11;
    } quad_t;
endpackage

// File: rtl/bilerp_delay.sv
module bilerp_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH+1];

    assign stage[0] = d;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i+1] <= '0;
            else     stage[i+1] <= stage[i];
        end
    end

    assign q = stage[DEPTH];
endmodule

// File: rtl/bilerp_weight_gen.sv
module bilerp_weight_gen #(
    parameter int FRAC_W = 12,
    localparam int WW    = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FRAC_W-1:0] frac_x,
    input  logic [FRAC_W-1:0] frac_y,
    output logic [WW-1:0]     w00,
    output logic [WW-1:0]     w10,
    output logic [WW-1:0]     w01,
    output logic [WW-1:0]     w11
);
    localparam logic [WW-1:0] ONE = {1'b1, {FRAC_W{1'b0}}};

    logic [2*FRAC_W-1:0] prod_full;
    logic [FRAC_W-1:0]   s1_p, s1_dx, s1_dy;
    logic [WW-1:0]       p_e, dx_e, dy_e;

    assign prod_full = frac_x * frac_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_p  <= '0;
            s1_dx <= '0;
            s1_dy <= '0;
        end else begin
            s1_p  <= prod_full[2*FRAC_W-1:FRAC_W];
            s1_dx <= frac_x;
            s1_dy <= frac_y;
        end
    end

    assign p_e  = {1'b0, s1_p};
    assign dx_e = {1'b0, s1_dx};
    assign dy_e = {1'b0, s1_dy};

    always_ff @(posedge clk) begin
        if (rst) begin
            w00 <= '0;
            w10 <= '0;
            w01 <= '0;
            w11 <= '0;
        end else begin
            w00 <= ONE + p_e - dx_e - dy_e;
            w10 <= dx_e - p_e;
            w01 <= dy_e - p_e;
            w11 <= p_e;
        end
    end
endmodule

// File: rtl/bilerp_channel.sv
module bilerp_channel #(
    parameter int FRAC_W = 12,
    localparam int WW    = FRAC_W + 1,
    localparam int SW    = FRAC_W + 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    c00,
    input  logic [7:0]    c10,
    input  logic [7:0]    c01,
    input  logic [7:0]    c11,
    input  logic [WW-1:0] w00,
    input  logic [WW-1:0] w10,
    input  logic [WW-1:0] w01,
    input  logic [WW-1:0] w11,
    input  logic          keep,
    output logic [7:0]    q
);
    logic [SW-1:0] acc_d, acc;
    logic [SW-1:0] quot;
    logic [7:0]    clamped;

    function automatic logic [SW-1:0] mul(input logic [7:0] c, input logic [WW-1:0] w);
        return {{(SW-8){1'b0}}, c} * {{(SW-WW){1'b0}}, w};
    endfunction

    assign acc_d = mul(c00, w00) + mul(c10, w10) + mul(c01, w01) + mul(c11, w11);

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc_d;
    end

    assign quot    = acc >> FRAC_W;
    assign clamped = (|quot[SW-1:8]) ? 8'hFF : quot[7:0];

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= keep ? clamped : 8'h00;
    end
endmodule

// File: rtl/rgb_bilerp.sv
module rgb_bilerp
    import bilerp_pkg::*;
#(
    parameter int FRAC_W = FRAC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_range,
    input  logic [23:0]       pix00,
    input  logic [23:0]       pix10,
    input  logic [23:0]       pix01,
    input  logic [23:0]       pix11,
    input  logic [FRAC_W-1:0] frac_x,
    input  logic [FRAC_W-1:0] frac_y,
    output logic              out_valid,
    output logic [23:0]       out_pix
);
    localparam int WW = FRAC_W + 1;

    quad_t         quad_in, quad_s2;
    ctl_t          ctl_in, ctl_s3;
    logic [WW-1:0] w00, w10, w01, w11;
    rgb_t          res;

    assign quad_in = '{p00: pix00, p10: pix10, p01: pix01, p11: pix11};
    assign ctl_in  = '{vld: in_valid, rng: in_range};

    bilerp_weight_gen #(.FRAC_W(FRAC_W)) u_wgen (
        .clk(clk), .rst(rst), .frac_x(frac_x), .frac_y(frac_y),
        .w00(w00), .w10(w10), .w01(w01), .w11(w11)
    );

    bilerp_delay #(.W($bits(quad_t)), .DEPTH(2)) u_pix_dly (
        .clk(clk), .rst(rst), .d(quad_in), .q(quad_s2)
    );

    bilerp_delay #(.W($bits(ctl_t)), .DEPTH(LATENCY-1)) u_ctl_dly (
        .clk(clk), .rst(rst), .d(ctl_in), .q(ctl_s3)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bilerp_channel #(.FRAC_W(FRAC_W)) u_ch (
            .clk(clk), .rst(rst),
            .c00(quad_s2.p00[c]), .c10(quad_s2.p10[c]),
            .c01(quad_s2.p01[c]), .c11(quad_s2.p11[c]),
            .w00(w00), .w10(w10), .w01(w01), .w11(w11),
            .keep(ctl_s3.vld & ctl_s3.rng),
            .q(res[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= ctl_s3.vld;
    end

    assign out_pix = res;
endmodule

// File: rtl/rgb_bilerp_chk.sv
module rgb_bilerp_chk #(
    parameter int FRAC_W = 12,
    localparam int WW    = FRAC_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_range,
    input logic [23:0]       pix00,
    input logic [FRAC_W-1:0] frac_x,
    input logic [FRAC_W-1:0] frac_y,
    input logic              out_valid,
    input logic [23:0]       out_pix,
    input logic [WW-1:0]     w00,
    input logic [WW-1:0]     w10,
    input logic [WW-1:0]     w01,
    input logic [WW-1:0]     w11
);
    localparam logic [WW-1:0] ONE = {1'b1, {FRAC_W{1'b0}}};

    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 4) since_rst <= since_rst + 3'd1;
    end

    p_weight_sum_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2) |-> (WW'(w00 + w10 + w01 + w11) == ONE));

    p_weight_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2) |-> (w00 <= ONE && w11 <= ONE));

    p_corner_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 4 && out_valid && $past(in_range, 4) &&
         $past(frac_x, 4) == '0 && $past(frac_y, 4) == '0)
        |-> out_pix == $past(pix00, 4));

    p_range_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 4 && out_valid && !$past(in_range, 4)) |-> out_pix == 24'h0);

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 4) |-> out_valid == $past(in_valid, 4));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_pix == 24'h0);

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 4) |-> !out_valid);
endmodule

bind rgb_bilerp rgb_bilerp_chk #(.FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_range(in_range),
    .pix00(pix00), .frac_x(frac_x), .frac_y(frac_y),
    .out_valid(out_valid), .out_pix(out_pix),
    .w00(w00), .w10(w10), .w01(w01), .w11(w11)
);

// File: tb/rgb_bilerp_bench.sv
module rgb_bilerp_bench;
    localparam int F  = 12;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_range = 1'b0;
    logic [23:0]   pix00 = '0, pix10 = '0, pix01 = '0, pix11 = '0;
    logic [F-1:0]  frac_x = '0, frac_y = '0;
    logic          out_valid;
    logic [23:0]   out_pix;

    int checks = 0;
    int failures = 0;

    rgb_bilerp #(.FRAC_W(F)) u_rgb_bilerp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_range(in_range),
        .pix00(pix00), .pix10(pix10), .pix01(pix01), .pix11(pix11),
        .frac_x(frac_x), .frac_y(frac_y),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    always #4 clk = ~clk;

    localparam logic [23:0] T00 [NV] = '{24'h102030, 24'hFF0000, 24'h00FF00, 24'h0000FF, 24'h123456,
                                          24'hFFFFFF, 24'h804020, 24'h000000, 24'h7F7F7F, 24'hC8641E};
    localparam logic [23:0] T10 [NV] = '{24'h405060, 24'h00FF00, 24'h0000FF, 24'hFF0000, 24'h654321,
                                          24'h000000, 24'h10F0A0, 24'hFFFFFF, 24'h808080, 24'h1E64C8};
    localparam logic [23:0] T01 [NV] = '{24'h708090, 24'h0000FF, 24'hFF0000, 24'h00FF00, 24'hABCDEF,
                                          24'h000000, 24'hE01060, 24'hFFFFFF, 24'h010203, 24'h3C3C3C};
    localparam logic [23:0] T11 [NV] = '{24'hA0B0C0, 24'h000000, 24'hFFFFFF, 24'h808080, 24'hFEDCBA,
                                          24'h000000, 24'h3355AA, 24'h000000, 24'hFDFEFF, 24'h9A9A9A};
    localparam logic [F-1:0] TDX [NV] = '{12'd0,    12'd2048, 12'd1024, 12'd0,    12'd4095,
                                          12'd4095, 12'd333,  12'd2049, 12'd3000, 12'd1};
    localparam logic [F-1:0] TDY [NV] = '{12'd0,    12'd2048, 12'd0,    12'd3072, 12'd4095,
                                          12'd4094, 12'd2900, 12'd2049, 12'd17,   12'd4095};

    function automatic logic [23:0] model(input logic [23:0] a, b, c, d,
                                          input logic [F-1:0] dx, dy);
        longint one, p, w00, w10, w01, w11, s, r;
        logic [23:0] res;
        one = 64'd1 << F;
        p   = (longint'(dx) * longint'(dy)) >> F;
        w00 = one + p - longint'(dx) - longint'(dy);
        w10 = longint'(dx) - p;
        w01 = longint'(dy) - p;
        w11 = p;
        res = '0;
        for (int ch = 0; ch < 3; ch++) begin
            s = longint'(a[8*ch +: 8]) * w00 + longint'(b[8*ch +: 8]) * w10 +
                longint'(c[8*ch +: 8]) * w01 + longint'(d[8*ch +: 8]) * w11;
            r = (s < 0) ? 0 : (s >> F);
            if (r > 255) r = 255;
            res[8*ch +: 8] = r[7:0];
        end
        return res;
    endfunction

    logic        h_v   [8];
    logic [23:0] h_pix [8];
    string       h_tag [8];
    int          step_n = 0;

    task automatic clear_hist();
        for (int i = 0; i < 8; i++) begin
            h_v[i] = 1'b0; h_pix[i] = '0; h_tag[i] = "R9";
        end
    endtask

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%06h expected=%06h", tag, act, exp_v);
        end
    endtask

    task automatic step(input logic v, input logic r, input logic [23:0] a, b, c, d,
                        input logic [F-1:0] dx, input logic [F-1:0] dy, input string tag);
        int old_i;
        int new_i;
        @(negedge clk);
        old_i = (step_n + 4) % 8;
        new_i = step_n % 8;
        check({h_tag[old_i], " valid (R6)"}, {23'd0, out_valid}, {23'd0, h_v[old_i]});
        check(h_tag[old_i], out_pix, h_pix[old_i]);
        in_valid = v; in_range = r;
        pix00 = a; pix10 = b; pix01 = c; pix11 = d;
        frac_x = dx; frac_y = dy;
        h_v[new_i]   = v;
        h_pix[new_i] = (v && r) ? model(a, b, c, d, dx, dy) : 24'h0;
        h_tag[new_i] = tag;
        step_n++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 24'hAAAAAA, 24'h555555, 24'h123456, 24'h654321, 12'd77, 12'd99, "R8");
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_hist();
        repeat (3) @(negedge clk);
        check("R9 reset out_pix", out_pix, 24'h0);
        check("R9 reset out_valid", {23'd0, out_valid}, 24'h0);
        rst = 1'b0;

        // R1 R2 R3 R4 R7: table streamed back to back
        for (int k = 0; k < NV; k++)
            step(1'b1, 1'b1, T00[k], T10[k], T01[k], T11[k], TDX[k], TDY[k], "R4 table");
        idle(4);

        // R3: zero offsets pass pix00 through; hand-known expected value
        step(1'b1, 1'b1, 24'h3C5A7E, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 12'd0, 12'd0, "R3 corner");
        idle(3);
        check("R3 corner literal", h_pix[(step_n + 4) % 8], 24'h3C5A7E);
        idle(1);

        // R2: half offsets average; channels 0,8,16 independent (R1)
        step(1'b1, 1'b1, 24'h000000, 24'h000004, 24'h000400, 24'h040000, 12'd2048, 12'd2048, "R1 half");
        idle(3);
        check("R1 half literal", h_pix[(step_n + 4) % 8], 24'h010101);
        idle(1);

        // R5: out of range samples mixed with in-range ones, with gaps
        step(1'b1, 1'b0, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 12'd100, 12'd200, "R5 range");
        step(1'b1, 1'b1, 24'h112233, 24'h445566, 24'h778899, 24'hAABBCC, 12'd1500, 12'd2500, "R5 neighbour");
        step(1'b0, 1'b1, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 12'd9, 12'd9, "R8 gap");
        step(1'b1, 1'b0, 24'h010203, 24'h040506, 24'h070809, 24'h0A0B0C, 12'd0, 12'd0, "R5 range");
        step(1'b1, 1'b1, 24'h10F0A0, 24'h0A0B0C, 24'hFFFFFF, 24'h000000, 12'd4000, 12'd5, "R7 stream");
        idle(5);

        // R9: reset with the pipeline full drops in-flight samples
        for (int k = 0; k < 3; k++)
            step(1'b1, 1'b1, T00[k], T10[k], T01[k], T11[k], TDX[k], TDY[k], "R9 pre");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        clear_hist();
        check("R9 after reset", out_pix, 24'h0);
        idle(6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule